// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block decides, every cycle, whether the instruction sitting in decode of a five-stage in-order pipeline can proceed, and with which operand values. It compares the source registers that decode actually needs against the destination registers of the instructions in the execute and memory stages. A match is resolved either by substituting a newer value (forwarding) or by holding the front of the pipeline for a cycle and sending a bubble down to execute. Operands consumed by ALU instructions and operands consumed by branch or jump-register resolution in decode follow separate rules.

The unit also turns exception indications from the execute and memory stages into clear signals for the pipeline registers and a redirect of the program counter. A two-bit mode input picks between no hazard handling, stall-only handling and stall-plus-forward handling at run time. The logic is purely combinational; the register file, pipeline registers and datapath sit outside.

Top module: `hazard_fwd_unit`

## Requirements
- R1: A stage is treated as a hazard only if its write enable is set, its destination is not register 0, and the destination equals a source whose need flag is set in decode; otherwise operands pass through unchanged, source codes are 2'b00 and no stall is raised.
- R2: In forwarding mode (mode 2'b10), an ALU operand matching the memory stage takes the memory-stage result and reports source code 2'b01 without stalling.
- R3: In stall-only mode (mode 2'b01), any ALU operand match against the memory or execute stage raises stall and nothing is forwarded.
- R4: In forwarding mode, an ALU operand matching the execute stage takes the execute ALU result with source code 2'b10, unless the execute instruction is a load, in which case stall is raised.
- R5: When both stages match the same ALU operand in forwarding mode, the execute-stage value and code win.
- R6: A branch/jump-register operand matching the execute stage raises stall in both stall-only and forwarding mode.
- R7: A branch/jump-register operand matching the memory stage (and no branch operand matching execute) is replaced by the memory result with its per-operand branch forward flag set in forwarding mode, and raises stall in stall-only mode.
- R8: A memory-stage exception asserts clear of the execute register, clear of the decode and fetch registers, and the PC redirect, with redirect address equal to the memory-stage instruction address plus 4.
- R9: An execute-stage exception alone clears the decode and fetch registers only, without redirect or execute clear.
- R10: While any exception is signalled, stall is held low.
- R11: In modes 2'b00 and 2'b11 the unit neither stalls nor forwards, while exception clears still act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode | input | 2 | 00/11 off, 01 stall-only, 10 stall plus forward |
| dec_rs | input | RW | First source register number in decode |
| dec_rt | input | RW | Second source register number in decode |
| dec_alu_rs | input | 1 | First source used as ALU operand |
| dec_alu_rt | input | 1 | Second source used as ALU operand |
| dec_br_rs | input | 1 | First source used by branch/jump-register |
| dec_br_rt | input | 1 | Second source used by branch/jump-register |
| dec_rs_val | input | DW | Register-file value of first source |
| dec_rt_val | input | DW | Register-file value of second source |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_rd | input | RW | Execute-stage destination register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ex_alu | input | DW | Execute-stage ALU result |
| ex_exc | input | 1 | Execute-stage instruction carries an exception |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_rd | input | RW | Memory-stage destination register |
| mem_result | input | DW | Memory-stage final result value |
| mem_exc | input | 1 | Memory-stage instruction carries an exception |
| mem_pc | input | AW | Memory-stage instruction address |
| opnd_a | output | DW | Resolved first operand |
| opnd_b | output | DW | Resolved second operand |
| src_a | output | 2 | First operand source code (00 none, 01 memory, 10 execute) |
| src_b | output | 2 | Second operand source code |
| brfwd_a | output | 1 | First branch operand taken from memory stage |
| brfwd_b | output | 1 | Second branch operand taken from memory stage |
| stall | output | 1 | Hold PC and fetch register, load bubble into decode-to-execute register |
| clr_ex | output | 1 | Clear execute-stage register |
| clr_front | output | 1 | Clear decode and fetch registers |
| redirect | output | 1 | Load PC with redirect_pc |
| redirect_pc | output | AW | Memory-stage address plus 4 |

## Verification
A data hazard that demands a stall and an exception flush can land in the same cycle, for example a load in execute feeding an ALU operand while the memory stage reports an exception. The bench builds exactly that input pattern, together with a branch-operand stall against an execute-stage exception, and judges that stall stays low while the clear and redirect outputs carry the exception's values. The rest of the vectors walk each hazard path in both active modes and in both off encodings.

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int RW = 5,
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic [1:0]    mode,
  input  logic [RW-1:0] dec_rs,
  input  logic [RW-1:0] dec_rt,
  input  logic          dec_alu_rs,
  input  logic          dec_alu_rt,
  input  logic          dec_br_rs,
  input  logic          dec_br_rt,
  input  logic [DW-1:0] dec_rs_val,
  input  logic [DW-1:0] dec_rt_val,
  input  logic          ex_we,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_load,
  input  logic [DW-1:0] ex_alu,
  input  logic          ex_exc,
  input  logic          mem_we,
  input  logic [RW-1:0] mem_rd,
  input  logic [DW-1:0] mem_result,
  input  logic          mem_exc,
  input  logic [AW-1:0] mem_pc,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b,
  output logic [1:0]    src_a,
  output logic [1:0]    src_b,
  output logic          brfwd_a,
  output logic          brfwd_b,
  output logic          stall,
  output logic          clr_ex,
  output logic          clr_front,
  output logic          redirect,
  output logic [AW-1:0] redirect_pc
);
  localparam logic [1:0] FW_NONE = 2'b00;
  localparam logic [1:0] FW_MEM  = 2'b01;
  localparam logic [1:0] FW_EX   = 2'b10;
  localparam int NOP = 2;

  logic en, fw, exc;
  assign fw  = (mode == 2'b10);
  assign en  = fw || (mode == 2'b01);
  assign exc = ex_exc || mem_exc;

  logic [NOP-1:0][RW-1:0] reg_n;
  logic [NOP-1:0][DW-1:0] reg_v;
  logic [NOP-1:0]         need_alu, need_br;
  logic [NOP-1:0]         alu_ex, alu_mem, br_ex, br_mem, brf;
  logic [NOP-1:0][1:0]    sel;
  logic [NOP-1:0][DW-1:0] res;

  assign reg_n    = {dec_rt, dec_rs};
  assign reg_v    = {dec_rt_val, dec_rs_val};
  assign need_alu = {dec_alu_rt, dec_alu_rs};
  assign need_br  = {dec_br_rt, dec_br_rs};

  logic ex_live, mem_live;
  assign ex_live  = en && ex_we && (ex_rd != '0);
  assign mem_live = en && mem_we && (mem_rd != '0);

  for (genvar g = 0; g < NOP; g++) begin : g_opnd
    logic ex_hit, mem_hit;
    assign ex_hit     = ex_live && (reg_n[g] == ex_rd);
    assign mem_hit    = mem_live && (reg_n[g] == mem_rd);
    assign alu_ex[g]  = need_alu[g] && ex_hit;
    assign alu_mem[g] = need_alu[g] && mem_hit;
    assign br_ex[g]   = need_br[g] && ex_hit;
    assign br_mem[g]  = need_br[g] && mem_hit;
    assign sel[g]     = (fw && alu_ex[g] && !ex_load) ? FW_EX :
                        (fw && alu_mem[g])            ? FW_MEM : FW_NONE;
    assign brf[g]     = fw && br_mem[g] && (br_ex == '0);
    assign res[g]     = (sel[g] == FW_EX) ? ex_alu :
                        ((sel[g] == FW_MEM) || brf[g]) ? mem_result : reg_v[g];
  end

  logic need_stall;
  assign need_stall = (|br_ex)
                   || (!fw && ((|alu_mem) || (|alu_ex) || (|br_mem)))
                   || (fw && ex_load && (|alu_ex));

  assign stall       = need_stall && !exc;
  assign opnd_a      = res[0];
  assign opnd_b      = res[1];
  assign src_a       = sel[0];
  assign src_b       = sel[1];
  assign brfwd_a     = brf[0];
  assign brfwd_b     = brf[1];
  assign clr_ex      = mem_exc;
  assign clr_front   = exc;
  assign redirect    = mem_exc;
  assign redirect_pc = mem_pc + AW'(4);
endmodule

module hazard_fwd_chk #(
  parameter int RW = 5,
  parameter int DW = 32,
  parameter int AW = 32
) (
  input logic [1:0]    mode,
  input logic [RW-1:0] ex_rd,
  input logic          ex_load,
  input logic [DW-1:0] ex_alu,
  input logic          ex_exc,
  input logic [RW-1:0] mem_rd,
  input logic [DW-1:0] mem_result,
  input logic          mem_exc,
  input logic [AW-1:0] mem_pc,
  input logic [DW-1:0] opnd_a,
  input logic [1:0]    src_a,
  input logic [1:0]    src_b,
  input logic          brfwd_a,
  input logic          brfwd_b,
  input logic          stall,
  input logic          clr_ex,
  input logic          clr_front,
  input logic          redirect,
  input logic [AW-1:0] redirect_pc
);
  always_comb begin
    if (ex_rd == '0 && mem_rd == '0)
      a_r1_zero_dest: assert (!stall && src_a == 2'b00 && src_b == 2'b00 && !brfwd_a && !brfwd_b)
        else $error("zero destinations produced a hazard");
    if (src_a == 2'b01)
      a_r2_mem_value: assert (opnd_a == mem_result) else $error("memory forward value wrong");
    if (mode == 2'b01)
      a_r3_no_fwd_stallonly: assert (src_a == 2'b00 && src_b == 2'b00 && !brfwd_a && !brfwd_b)
        else $error("forward in stall-only mode");
    if (src_a == 2'b10)
      a_r4_ex_value: assert (opnd_a == ex_alu && !ex_load) else $error("execute forward wrong");
    if (mem_exc)
      a_r8_redirect: assert (redirect && clr_ex && clr_front && redirect_pc == mem_pc + AW'(4))
        else $error("memory exception handling wrong");
    if (ex_exc && !mem_exc)
      a_r9_front_only: assert (clr_front && !clr_ex && !redirect) else $error("execute exception wrong");
    if (ex_exc || mem_exc)
      a_r10_exc_no_stall: assert (!stall) else $error("stall during exception");
    if (mode == 2'b00 || mode == 2'b11)
      a_r11_off: assert (!stall && src_a == 2'b00 && src_b == 2'b00 && !brfwd_a && !brfwd_b)
        else $error("unit active while off");
  end
endmodule

bind hazard_fwd_unit hazard_fwd_chk #(.RW(RW), .DW(DW), .AW(AW)) u_chk (
  .mode(mode), .ex_rd(ex_rd), .ex_load(ex_load), .ex_alu(ex_alu), .ex_exc(ex_exc),
  .mem_rd(mem_rd), .mem_result(mem_result), .mem_exc(mem_exc), .mem_pc(mem_pc),
  .opnd_a(opnd_a), .src_a(src_a), .src_b(src_b), .brfwd_a(brfwd_a), .brfwd_b(brfwd_b),
  .stall(stall), .clr_ex(clr_ex), .clr_front(clr_front), .redirect(redirect),
  .redirect_pc(redirect_pc)
);

// File: tb/test_hazard_fwd_unit.sv
module test_hazard_fwd_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    logic [1:0] mode; logic [4:0] rs, rt; logic ar, at, br, bt;
    logic [31:0] rsv, rtv; logic ewe; logic [4:0] erd; logic eld; logic [31:0] ealu;
    logic eexc, mwe; logic [4:0] mrd; logic [31:0] mres; logic mexc; logic [31:0] mpc;
  } stim_t;

  typedef struct packed {
    logic [31:0] opa, opb; logic [1:0] asrc, bsrc;
    logic fa, fb, stall, cex, cfront, redir; logic [31:0] rpc;
  } exp_t;

  typedef struct { string tag; exp_t e; } item_t;

  stim_t s;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] opnd_a, opnd_b, redirect_pc;
  logic [1:0] src_a, src_b;
  logic brfwd_a, brfwd_b, stall, clr_ex, clr_front, redirect;

  hazard_fwd_unit i_hazard_fwd_unit (
    .mode(s.mode), .dec_rs(s.rs), .dec_rt(s.rt), .dec_alu_rs(s.ar), .dec_alu_rt(s.at),
    .dec_br_rs(s.br), .dec_br_rt(s.bt), .dec_rs_val(s.rsv), .dec_rt_val(s.rtv),
    .ex_we(s.ewe), .ex_rd(s.erd), .ex_load(s.eld), .ex_alu(s.ealu), .ex_exc(s.eexc),
    .mem_we(s.mwe), .mem_rd(s.mrd), .mem_result(s.mres), .mem_exc(s.mexc), .mem_pc(s.mpc),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .src_a(src_a), .src_b(src_b),
    .brfwd_a(brfwd_a), .brfwd_b(brfwd_b), .stall(stall), .clr_ex(clr_ex),
    .clr_front(clr_front), .redirect(redirect), .redirect_pc(redirect_pc));

  function automatic stim_t idle();
    stim_t t;
    t = '{mode:2'b10, rs:5'd1, rt:5'd2, ar:0, at:0, br:0, bt:0,
          rsv:32'h1111_0001, rtv:32'h2222_0002, ewe:0, erd:5'd0, eld:0, ealu:32'hEEEE_0000,
          eexc:0, mwe:0, mrd:5'd0, mres:32'hAAAA_0000, mexc:0, mpc:32'h0000_0040};
    return t;
  endfunction

  function automatic exp_t pass(stim_t t);
    exp_t e;
    e = '{opa:t.rsv, opb:t.rtv, asrc:2'b00, bsrc:2'b00, fa:0, fb:0, stall:0,
          cex:0, cfront:0, redir:0, rpc:t.mpc + 32'd4};
    return e;
  endfunction

  task automatic run(string tag, stim_t t, exp_t e);
    item_t it;
    @(posedge clk); #1;
    s = t;
    it.tag = tag; it.e = e;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      exp_t got;
      it = q.pop_front();
      got = '{opa:opnd_a, opb:opnd_b, asrc:src_a, bsrc:src_b, fa:brfwd_a, fb:brfwd_b,
              stall:stall, cex:clr_ex, cfront:clr_front, redir:redirect, rpc:redirect_pc};
      checks++;
      if (got !== it.e) begin
        errors++;
        $display("FAIL %s got %h expected %h", it.tag, got, it.e);
      end
    end
  end

  initial begin
    stim_t t; exp_t e;
    s = idle();
    // R1 quiet start: everything passes through
    t = idle(); e = pass(t); run("R1 idle", t, e);
    // R1 destination register 0 never matches
    t = idle(); t.rs = 0; t.ar = 1; t.mwe = 1; t.mrd = 0; t.ewe = 1; t.erd = 0;
    e = pass(t); run("R1 dest zero", t, e);
    // R1 source not needed
    t = idle(); t.ewe = 1; t.erd = 1; t.mwe = 1; t.mrd = 2; e = pass(t); run("R1 not needed", t, e);
    // R1 write enable low
    t = idle(); t.ar = 1; t.erd = 1; t.eld = 1; e = pass(t); run("R1 no write", t, e);
    // R2 memory forward on rt
    t = idle(); t.at = 1; t.mwe = 1; t.mrd = 2; e = pass(t); e.opb = t.mres; e.bsrc = 2'b01;
    run("R2 mem fwd", t, e);
    // R3 stall-only on memory match
    t.mode = 2'b01; e = pass(t); e.stall = 1; run("R3 mem stall", t, e);
    // R3 stall-only on execute match
    t = idle(); t.mode = 2'b01; t.ar = 1; t.ewe = 1; t.erd = 1; e = pass(t); e.stall = 1;
    run("R3 ex stall", t, e);
    // R4 execute forward on rs
    t = idle(); t.ar = 1; t.ewe = 1; t.erd = 1; e = pass(t); e.opa = t.ealu; e.asrc = 2'b10;
    run("R4 ex fwd", t, e);
    // R4 load in execute stalls
    t.eld = 1; e = pass(t); e.stall = 1; run("R4 load stall", t, e);
    // R5 both stages match, execute wins
    t = idle(); t.ar = 1; t.ewe = 1; t.erd = 1; t.mwe = 1; t.mrd = 1;
    e = pass(t); e.opa = t.ealu; e.asrc = 2'b10; run("R5 ex over mem", t, e);
    // R6 branch operand vs execute, forwarding mode
    t = idle(); t.bt = 1; t.ewe = 1; t.erd = 2; e = pass(t); e.stall = 1; run("R6 br ex fwdmode", t, e);
    // R6 same in stall-only mode
    t.mode = 2'b01; run("R6 br ex stallonly", t, e);
    // R7 branch operand from memory, forwarding mode
    t = idle(); t.br = 1; t.mwe = 1; t.mrd = 1; e = pass(t); e.opa = t.mres; e.fa = 1;
    run("R7 br mem fwd", t, e);
    // R7 stall-only
    t.mode = 2'b01; e = pass(t); e.stall = 1; run("R7 br mem stall", t, e);
    // R8 memory exception
    t = idle(); t.mexc = 1; t.mpc = 32'h0000_0100; e = pass(t);
    e.cex = 1; e.cfront = 1; e.redir = 1; e.rpc = 32'h0000_0104; run("R8 mem exc", t, e);
    // R9 execute exception
    t = idle(); t.eexc = 1; e = pass(t); e.cfront = 1; run("R9 ex exc", t, e);
    // R10 load stall collides with memory exception
    t = idle(); t.ar = 1; t.ewe = 1; t.erd = 1; t.eld = 1; t.mexc = 1; t.mpc = 32'hFFFF_FFFC;
    e = pass(t); e.cex = 1; e.cfront = 1; e.redir = 1; e.rpc = 32'h0; run("R10 stall vs mem exc", t, e);
    // R10 branch stall collides with execute exception
    t = idle(); t.br = 1; t.ewe = 1; t.erd = 1; t.eexc = 1; e = pass(t); e.cfront = 1;
    run("R10 stall vs ex exc", t, e);
    // R11 mode 00 ignores memory match
    t = idle(); t.mode = 2'b00; t.ar = 1; t.mwe = 1; t.mrd = 1; e = pass(t); run("R11 mode 00", t, e);
    // R11 mode 11 ignores branch vs execute, exception still clears
    t = idle(); t.mode = 2'b11; t.br = 1; t.ewe = 1; t.erd = 1; t.eexc = 1; e = pass(t); e.cfront = 1;
    run("R11 mode 11", t, e);
    @(posedge clk);
    @(negedge clk); #1;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule